// File: doc/BRIEF.md
# Strobed Handshake Parallel Port

This block is an 8-bit parallel port that sits between a CPU bus and a peripheral. The peripheral side has a data port, a strobe input, a ready output and an active-high interrupt output. The CPU side has a chip select, a 2-bit register address, write and read data buses, a read timing pulse, and a write window. The write window is open while the first direction qualifier is 0 and the second is 1. All inputs are sampled on the block clock, and every handshake action is tied to a sampled edge of the read pulse, the write window or the strobe.

A single mode bit in the control register selects the direction.

- **Input mode.** A strobe rising edge captures the peripheral byte, drops ready and raises the interrupt. The CPU then reads the data register: the leading edge of the read pulse clears the interrupt, and the trailing edge raises ready again. Ready is low after reset and after every mode change, so one dummy read is needed before the first transfer.
- **Output mode.** A strobe rising edge tells the CPU that the peripheral wants data. The CPU opens a write window to the data register. The opening clears the interrupt, and the closing captures the byte and raises ready.

Top module: `hsk_port`

## Requirements
- R1: While reset is held, and on the cycle after it, ready and interrupt are low, the buffer is zero, the mode is input (control bit 0 = 0) and the output enable is low.
- R2: In input mode, a sampled rising edge of the strobe loads the peripheral byte into the buffer, drives ready low and drives the interrupt high, visible one cycle after the edge.
- R3: In input mode, the sampled leading edge of a read pulse with chip select high and address 1 (the data register) clears the interrupt. While chip select is high and the address is 1, the read bus shows the buffer.
- R4: In input mode, the sampled trailing edge of a read pulse whose leading edge hit the data register sets ready. This also applies to a dummy read after reset, when no strobe has occurred.
- R5: In output mode, the closing of a write window that addressed the data register loads the buffer with the write data sampled on the last open cycle and sets ready. The peripheral output shows the buffer, and the output enable is high.
- R6: In output mode, the opening of a write window with chip select high and address 1 clears the interrupt.
- R7: In output mode, a strobe rising edge drives ready low and the interrupt high, and leaves the buffer unchanged.
- R8: The closing of a write window that addressed address 0 (control) sets the mode from write data bit 0 (1 = output) and clears ready and interrupt. A read at address 0 returns the mode in bit 0, with the other bits 0.
- R9: Reads and write windows with chip select low, or with address 2 or 3, change neither ready, the interrupt nor the buffer. Reads at addresses 2 and 3 return 0.
- R10: A data-register write in input mode, and a data-register read in output mode, change neither the buffer, ready nor the interrupt.
- R11: When a CPU event and a strobe edge fall on the same cycle, the CPU event's effect on ready or the interrupt takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| reg_addr | input | 2 | Register address: 0 control, 1 data |
| bus_wdata | input | 8 | Write data from the CPU |
| bus_rdata | output | 8 | Read data to the CPU |
| rd_pulse | input | 1 | Read timing pulse, active high |
| dir_a | input | 1 | First write-window qualifier (window needs 0) |
| dir_b | input | 1 | Second write-window qualifier (window needs 1) |
| pio_in | input | 8 | Peripheral data in |
| pio_out | output | 8 | Peripheral data out (buffer) |
| pio_oe | output | 1 | Peripheral output enable, high in output mode |
| strobe_in | input | 1 | Peripheral strobe |
| rdy_out | output | 1 | Ready to the peripheral |
| int_out | output | 1 | Interrupt to the CPU, active high |

## Verification
A wrong ready or interrupt state shows on the ports in the cycle after the edge that should have changed it. Because the reference model is compared every cycle, a missed clear or a lost set is reported within one clock. A corrupted buffer or mode shows on the next data or control read, or at once on the peripheral output and output enable in output mode. A dropped dummy-read ready after reset shows when the first read pulse ends, and ready then stays low.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 2'd0,
        REG_DATA  = 2'd1,
        REG_RSV_2 = 2'd2,
        REG_RSV_3 = 2'd3
    } reg_sel_e;

    typedef enum logic {
        MODE_IN  = 1'b0,
        MODE_OUT = 1'b1
    } port_mode_e;

    typedef struct packed {
        logic              rd_open_data;
        logic              rd_close_data;
        logic              wr_open_data;
        logic              wr_close_data;
        logic              wr_close_ctrl;
        logic [DATA_W-1:0] wr_value;
    } cpu_evt_t;

    function automatic logic sel_hit(input logic cs, input logic [ADDR_W-1:0] addr,
                                     input reg_sel_e want);
        return cs && (reg_sel_e'(addr) == want);
    endfunction

endpackage

// File: rtl/hsk_edge.sv
module hsk_edge (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic prev_o
);
    always_ff @(posedge clk) begin
        if (rst) prev_o <= 1'b0;
        else     prev_o <= level_i;
    end
endmodule

// File: rtl/hsk_cpu_if.sv
module hsk_cpu_if
    import hsk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              rd_pulse,
    input  logic              dir_a,
    input  logic              dir_b,
    output cpu_evt_t          evt_o
);
    logic              win_now, win_prev, rd_prev;
    logic              rd_lead, rd_trail, win_open, win_close;
    logic              rd_hit_q;
    logic              stg_cs;
    logic [ADDR_W-1:0] stg_addr;
    logic [DATA_W-1:0] stg_data;

    assign win_now = ~dir_a & dir_b;

    hsk_edge u_rd_edge  (.clk(clk), .rst(rst), .level_i(rd_pulse), .prev_o(rd_prev));
    hsk_edge u_win_edge (.clk(clk), .rst(rst), .level_i(win_now),  .prev_o(win_prev));

    assign rd_lead   =  rd_pulse & ~rd_prev;
    assign rd_trail  = ~rd_pulse &  rd_prev;
    assign win_open  =  win_now  & ~win_prev;
    assign win_close = ~win_now  &  win_prev;

    // Read target is latched at the leading edge; trailing action uses it.
    // Write target and data are staged on every open cycle; the last one counts.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_hit_q <= 1'b0;
            stg_cs   <= 1'b0;
            stg_addr <= '0;
            stg_data <= '0;
        end else begin
            if (rd_lead) rd_hit_q <= sel_hit(cs, reg_addr, REG_DATA);
            if (win_now) begin
                stg_cs   <= cs;
                stg_addr <= reg_addr;
                stg_data <= bus_wdata;
            end
        end
    end

    always_comb begin
        evt_o.rd_open_data  = rd_lead  && sel_hit(cs, reg_addr, REG_DATA);
        evt_o.rd_close_data = rd_trail && rd_hit_q;
        evt_o.wr_open_data  = win_open && sel_hit(cs, reg_addr, REG_DATA);
        evt_o.wr_close_data = win_close && sel_hit(stg_cs, stg_addr, REG_DATA);
        evt_o.wr_close_ctrl = win_close && sel_hit(stg_cs, stg_addr, REG_CTRL);
        evt_o.wr_value      = stg_data;
    end

    // R9: a read trailing edge only acts if its leading edge hit the data register
    assert_rd_close_needs_hit_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_lead && !sel_hit(cs, reg_addr, REG_DATA)) |=> !evt_o.rd_close_data);
endmodule

// File: rtl/hsk_core.sv
module hsk_core
    import hsk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cpu_evt_t          evt_i,
    input  logic              cs,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] pio_in,
    input  logic              strobe_in,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] pio_out,
    output logic              pio_oe,
    output logic              rdy_out,
    output logic              int_out
);
    port_mode_e        mode_q;
    logic [DATA_W-1:0] buf_q;
    logic              stb_prev, stb_rise;
    logic              any_evt;

    hsk_edge u_stb_edge (.clk(clk), .rst(rst), .level_i(strobe_in), .prev_o(stb_prev));
    assign stb_rise = strobe_in & ~stb_prev;

    // Strobe effects first; CPU-side effects below override on coincidence (R11).
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_IN;
            buf_q   <= '0;
            rdy_out <= 1'b0;
            int_out <= 1'b0;
        end else begin
            if (stb_rise) begin
                rdy_out <= 1'b0;
                int_out <= 1'b1;
                if (mode_q == MODE_IN) buf_q <= pio_in;
            end
            if (mode_q == MODE_IN) begin
                if (evt_i.rd_open_data)  int_out <= 1'b0;
                if (evt_i.rd_close_data) rdy_out <= 1'b1;
            end else begin
                if (evt_i.wr_open_data) int_out <= 1'b0;
                if (evt_i.wr_close_data) begin
                    buf_q   <= evt_i.wr_value;
                    rdy_out <= 1'b1;
                end
            end
            if (evt_i.wr_close_ctrl) begin
                mode_q  <= port_mode_e'(evt_i.wr_value[0]);
                rdy_out <= 1'b0;
                int_out <= 1'b0;
            end
        end
    end

    always_comb begin
        if (sel_hit(cs, reg_addr, REG_DATA))      bus_rdata = buf_q;
        else if (sel_hit(cs, reg_addr, REG_CTRL)) bus_rdata = {{(DATA_W-1){1'b0}}, mode_q};
        else                                      bus_rdata = '0;
    end

    assign pio_out = buf_q;
    assign pio_oe  = (mode_q == MODE_OUT);

    assign any_evt = evt_i.rd_open_data | evt_i.rd_close_data | evt_i.wr_open_data |
                     evt_i.wr_close_data | evt_i.wr_close_ctrl;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!rdy_out && !int_out && buf_q == '0 && mode_q == MODE_IN));

    assert_in_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        (stb_rise && mode_q == MODE_IN && !evt_i.rd_open_data && !evt_i.wr_close_ctrl)
        |=> (int_out && buf_q == $past(pio_in)));

    assert_out_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        (stb_rise && mode_q == MODE_OUT && !evt_i.wr_close_data && !evt_i.wr_close_ctrl)
        |=> (!rdy_out && $stable(buf_q)));

    assert_ctrl_clears_R8: assert property (@(posedge clk) disable iff (rst)
        evt_i.wr_close_ctrl |=> (!rdy_out && !int_out));

    assert_quiet_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!stb_rise && !any_evt) |=> ($stable(rdy_out) && $stable(int_out) && $stable(buf_q)));
endmodule

// File: rtl/hsk_port.sv
module hsk_port
    import hsk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rd_pulse,
    input  logic              dir_a,
    input  logic              dir_b,
    input  logic [DATA_W-1:0] pio_in,
    output logic [DATA_W-1:0] pio_out,
    output logic              pio_oe,
    input  logic              strobe_in,
    output logic              rdy_out,
    output logic              int_out
);
    cpu_evt_t evt;

    hsk_cpu_if u_cpu_if (
        .clk(clk), .rst(rst), .cs(cs), .reg_addr(reg_addr), .bus_wdata(bus_wdata),
        .rd_pulse(rd_pulse), .dir_a(dir_a), .dir_b(dir_b), .evt_o(evt)
    );

    hsk_core u_core (
        .clk(clk), .rst(rst), .evt_i(evt), .cs(cs), .reg_addr(reg_addr),
        .pio_in(pio_in), .strobe_in(strobe_in), .bus_rdata(bus_rdata),
        .pio_out(pio_out), .pio_oe(pio_oe), .rdy_out(rdy_out), .int_out(int_out)
    );
endmodule

// File: tb/hsk_port_bench.sv
`timescale 1ns/1ps
module hsk_port_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs = 1'b0, rd_pulse = 1'b0, dir_a = 1'b1, dir_b = 1'b0, strobe_in = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0, pio_in = 8'd0;
    logic [7:0] bus_rdata, pio_out;
    logic       pio_oe, rdy_out, int_out;

    int    n_chk = 0, n_bad = 0;
    string cur_req = "R1";
    bit    done = 1'b0;
    logic [7:0] last_rd;
    logic       win_int;

    always #2 clk = ~clk;

    hsk_port u_hsk_port (
        .clk(clk), .rst(rst), .cs(cs), .reg_addr(reg_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rd_pulse(rd_pulse), .dir_a(dir_a), .dir_b(dir_b),
        .pio_in(pio_in), .pio_out(pio_out), .pio_oe(pio_oe), .strobe_in(strobe_in),
        .rdy_out(rdy_out), .int_out(int_out)
    );

    // Behavioural reference model
    int m_mode, m_rdy, m_int, m_buf;
    int p_rd, p_win, p_stb, r_hit, s_cs, s_addr, s_data;

    task automatic cmp(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_rdy = 0; m_int = 0; m_buf = 0;
            p_rd = 0; p_win = 0; p_stb = 0; r_hit = 0; s_cs = 0; s_addr = 0; s_data = 0;
        end else begin
            int win, rl, rt, wo, wc, sr, hit_now;
            win = (!dir_a && dir_b) ? 1 : 0;
            rl = (rd_pulse && !p_rd) ? 1 : 0;
            rt = (!rd_pulse && p_rd) ? 1 : 0;
            wo = (win && !p_win) ? 1 : 0;
            wc = (!win && p_win) ? 1 : 0;
            sr = (strobe_in && !p_stb) ? 1 : 0;
            hit_now = (cs && reg_addr == 2'd1) ? 1 : 0;
            if (sr) begin
                m_rdy = 0; m_int = 1;
                if (m_mode == 0) m_buf = pio_in;
            end
            if (m_mode == 0) begin
                if (rl && hit_now) m_int = 0;
                if (rt && r_hit) m_rdy = 1;
            end else begin
                if (wo && hit_now) m_int = 0;
                if (wc && s_cs && s_addr == 1) begin m_buf = s_data; m_rdy = 1; end
            end
            if (wc && s_cs && s_addr == 0) begin m_mode = s_data & 1; m_rdy = 0; m_int = 0; end
            if (rl) r_hit = hit_now;
            if (win) begin s_cs = cs; s_addr = reg_addr; s_data = bus_wdata; end
            p_rd = rd_pulse; p_win = win; p_stb = strobe_in;
        end
        #1;
        if (!done) begin
            int exp_rd;
            if (cs && reg_addr == 2'd1)      exp_rd = m_buf;
            else if (cs && reg_addr == 2'd0) exp_rd = m_mode;
            else                             exp_rd = 0;
            n_chk++;
            if (rdy_out !== m_rdy[0] || int_out !== m_int[0] || pio_out !== m_buf[7:0] ||
                pio_oe !== m_mode[0] || bus_rdata !== exp_rd[7:0]) begin
                n_bad++;
                $display("FAIL %s cycle rdy/int/out/oe/rd actual %0d/%0d/%0h/%0d/%0h expected %0d/%0d/%0h/%0d/%0h",
                         cur_req, rdy_out, int_out, pio_out, pio_oe, bus_rdata,
                         m_rdy, m_int, m_buf, m_mode, exp_rd);
            end
        end
    end

    task automatic cpu_write(input logic [1:0] a, input logic [7:0] d, input logic c);
        @(negedge clk); cs = c; reg_addr = a; bus_wdata = d; dir_a = 1'b0; dir_b = 1'b1;
        @(negedge clk); win_int = int_out;
        @(negedge clk); dir_b = 1'b0; dir_a = 1'b1; cs = 1'b0; reg_addr = 2'd0;
        @(negedge clk);
    endtask

    task automatic cpu_read(input logic [1:0] a, input logic c);
        @(negedge clk); cs = c; reg_addr = a; rd_pulse = 1'b1;
        @(negedge clk); last_rd = bus_rdata;
        @(negedge clk); rd_pulse = 1'b0;
        @(negedge clk); cs = 1'b0; reg_addr = 2'd0;
    endtask

    task automatic strobe(input logic [7:0] d);
        @(negedge clk); pio_in = d; strobe_in = 1'b1;
        @(negedge clk); strobe_in = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cmp("R1 rdy during reset", rdy_out, 0);
        cmp("R1 int during reset", int_out, 0);
        rst = 1'b0;
        @(negedge clk);
        cmp("R1 buffer", pio_out, 8'h00);
        cmp("R1 oe", pio_oe, 0);

        cur_req = "R4";
        cpu_read(2'd1, 1'b1);
        cmp("R4 dummy read sets rdy", rdy_out, 1);

        cur_req = "R2";
        strobe(8'hA5);
        cmp("R2 int", int_out, 1);
        cmp("R2 rdy", rdy_out, 0);

        cur_req = "R3";
        cpu_read(2'd1, 1'b1);
        cmp("R3 read data", last_rd, 8'hA5);
        cmp("R3 int cleared", int_out, 0);
        cmp("R4 rdy after read", rdy_out, 1);

        cur_req = "R9";
        strobe(8'h3C);
        cpu_read(2'd1, 1'b0);
        cmp("R9 cs low read keeps int", int_out, 1);
        cpu_read(2'd2, 1'b1);
        cmp("R9 addr 2 read data", last_rd, 8'h00);
        cmp("R9 addr 2 keeps rdy", rdy_out, 0);
        cpu_write(2'd3, 8'h01, 1'b1);
        cmp("R9 addr 3 write keeps mode", pio_oe, 0);
        cpu_write(2'd0, 8'h01, 1'b0);
        cmp("R9 cs low ctrl write keeps mode", pio_oe, 0);

        cur_req = "R10";
        cpu_write(2'd1, 8'h99, 1'b1);
        cmp("R10 input-mode write keeps buffer", pio_out, 8'h3C);
        cmp("R10 input-mode write keeps int", int_out, 1);
        cpu_read(2'd1, 1'b1);

        cur_req = "R8";
        cpu_write(2'd0, 8'hFF, 1'b1);
        cmp("R8 mode out", pio_oe, 1);
        cmp("R8 rdy cleared", rdy_out, 0);
        cpu_read(2'd0, 1'b1);
        cmp("R8 ctrl readback", last_rd, 8'h01);

        cur_req = "R7";
        strobe(8'hEE);
        cmp("R7 int", int_out, 1);
        cmp("R7 buffer held", pio_out, 8'h3C);

        cur_req = "R6";
        cpu_write(2'd1, 8'h5A, 1'b1);
        cmp("R6 int cleared in window", win_int, 0);
        cmp("R5 out data", pio_out, 8'h5A);
        cmp("R5 rdy set", rdy_out, 1);

        cur_req = "R7";
        strobe(8'hFF);
        cmp("R7 rdy cleared", rdy_out, 0);
        cmp("R7 buffer held again", pio_out, 8'h5A);

        cur_req = "R10";
        cpu_read(2'd1, 1'b1);
        cmp("R10 output-mode read keeps int", int_out, 1);
        cmp("R10 output-mode read keeps rdy", rdy_out, 0);

        cur_req = "R5";
        for (int i = 0; i < 12; i++) begin
            strobe(8'(i * 17));
            cpu_write(2'd1, 8'(i * 37 + 5), 1'b1);
            cmp("R5 sweep out data", pio_out, (i * 37 + 5) & 8'hFF);
        end

        cur_req = "R11";
        // Strobe rise on the same edge as a data-register read leading edge
        cpu_write(2'd0, 8'h00, 1'b1);
        cpu_read(2'd1, 1'b1);
        @(negedge clk); pio_in = 8'h42; strobe_in = 1'b1; cs = 1'b1; reg_addr = 2'd1; rd_pulse = 1'b1;
        @(negedge clk); strobe_in = 1'b0;
        cmp("R11 read clear wins over strobe", int_out, 0);
        cmp("R11 buffer still loads", pio_out, 8'h42);
        @(negedge clk); rd_pulse = 1'b0;
        @(negedge clk); cs = 1'b0;
        cmp("R4 rdy after coincident read", rdy_out, 1);

        cur_req = "R2";
        for (int i = 0; i < 10; i++) begin
            strobe(8'(i * 29 + 3));
            cmp("R2 sweep int", int_out, 1);
            cpu_read(2'd1, 1'b1);
            cmp("R3 sweep read", last_rd, (i * 29 + 3) & 8'hFF);
        end

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog %s actual hung expected done", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule